// File: doc/BRIEF.md
# Sprite-Over-Background Pixel Compositor

This block drives the read addresses of two pixel planes, a background plane and a sprite plane, and picks which plane's 15-bit colour reaches a registered RGB output on each pixel clock. Each plane address splits into a low offset counter and an upper page. A position-load strobe sets the counter. A separate preload strobe sets the page, and the page never counts. The memories sit outside the block and return one 16-bit word for the address currently presented.

A sprite has no fixed width. A start strobe, which may come at any pixel position, makes the sprite active. The sprite then runs until its own data holds a transparent pixel that also carries an end marker. That end condition goes through one register before it clears the active state. Several sprites can be started on one line, including one that starts while another is still running.

Top module: `sprite_compositor`

## Requirements
- R1: Each plane address is the plane's page register (upper 6 bits) joined to its offset counter (lower 12 bits). A page register changes only on the edge where its own page strobe is high, and then takes `page_val`.
- R2: On the edge where a plane's position strobe is high, that plane's offset counter takes `pos_val`. This holds even when `adv_en` is also high.
- R3: When a plane's position strobe is low, its offset counter rises by one on each edge where `adv_en` is high. It holds its value on each edge where `adv_en` is low.
- R4: The offset counter wraps from 0xFFF to 0x000 and never changes the page bits.
- R5: A sprite start strobe (`fg_pos_ld`) makes the sprite active from the next cycle. This holds at any time, including while a sprite is already active.
- R6: A sprite word with bit 15 = 1 and bit 14 = 1 is an end marker, whether or not a sprite is active. It is captured in a register on that edge, and that register clears the active state on the following edge. The sprite pixel read in the cycle after the marker is therefore still shown.
- R7: If a start strobe and a registered end marker fall on the same edge, the sprite stays active.
- R8: The output takes sprite bits 14:0 when the sprite is active and sprite bit 15 = 0. In every other case it takes background bits 14:0. Sprite bit 14 with bit 15 = 0 is ordinary colour and does not end the sprite.
- R9: `rgb_out` is registered. It shows the selection made from the inputs and state of the cycle before the edge, and background bit 15 never reaches it.
- R10: Synchronous reset clears both addresses, both pages, the sprite state and `rgb_out` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance both offset counters this cycle |
| page_val | input | 6 | Page value for a page preload |
| bg_page_wr | input | 1 | Preload the background page |
| fg_page_wr | input | 1 | Preload the sprite page |
| pos_val | input | 12 | Offset for a position load |
| bg_pos_ld | input | 1 | Load the background offset counter |
| fg_pos_ld | input | 1 | Load the sprite offset counter and start a sprite |
| bg_rdata | input | 16 | Background word read at `bg_addr` |
| fg_rdata | input | 16 | Sprite word read at `fg_addr` |
| bg_addr | output | 18 | Background read address |
| fg_addr | output | 18 | Sprite read address |
| rgb_out | output | 15 | Registered 5-5-5 colour |

## Verification
The bench plays a pixel stream through a full sprite lifetime. It checks the pixel just after an end marker, which the register delay must still show as sprite. A design with no delay would drop that pixel, and one with too much delay would show an extra pixel. The stream also puts a start strobe on the same edge as a pending end, where a wrong priority would kill the new sprite. It sends an end marker while no sprite is active, and a bit-14-only word that must stay ordinary colour. On the address side, the bench drives the counter across 0xFFF, where a carry into the page would corrupt the upper bits. It also loads while advancing, where the wrong precedence gives pos_val+1.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [0:0] {
    PLANE_BG = 1'b0,
    PLANE_FG = 1'b1
  } plane_e;

  localparam int NUM_PLANES = 2;

  // Lower RGB field of a pixel word (everything below the flag bit).
  function automatic logic [14:0] colour_of(input logic [15:0] word);
    return word[14:0];
  endfunction
endpackage

// File: rtl/spc_plane_addr.sv
module spc_plane_addr #(
  parameter int POS_W  = 12,
  parameter int PAGE_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    page_wr,
  input  logic [PAGE_W-1:0]       page_val,
  input  logic                    pos_ld,
  input  logic [POS_W-1:0]        pos_val,
  input  logic                    adv_en,
  output logic [POS_W+PAGE_W-1:0] addr
);
  localparam int ADDR_W = POS_W + PAGE_W;

  logic [PAGE_W-1:0] page_q;
  logic [POS_W-1:0]  ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
    end else if (page_wr) begin
      page_q <= page_val;
    end
  end

  // Offset counter: load beats advance; natural modulo wrap keeps it in page.
  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q <= '0;
    end else if (pos_ld) begin
      ofs_q <= pos_val;
    end else if (adv_en) begin
      ofs_q <= ofs_q + POS_W'(1);
    end
  end

  assign addr = {page_q, ofs_q};

  assert_page_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !page_wr |=> addr[ADDR_W-1:POS_W] == $past(addr[ADDR_W-1:POS_W]));
  assert_page_load_R1: assert property (@(posedge clk) disable iff (rst)
    page_wr |=> addr[ADDR_W-1:POS_W] == $past(page_val));
  assert_pos_load_R2: assert property (@(posedge clk) disable iff (rst)
    pos_ld |=> addr[POS_W-1:0] == $past(pos_val));
  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (!pos_ld && adv_en) |=> addr[POS_W-1:0] == POS_W'($past(addr[POS_W-1:0]) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!pos_ld && !adv_en) |=> $stable(addr[POS_W-1:0]));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (!pos_ld && adv_en && !page_wr && (&addr[POS_W-1:0]))
      |=> (addr[POS_W-1:0] == '0) && $stable(addr[ADDR_W-1:POS_W]));
endmodule

// File: rtl/spc_sprite_track.sv
module spc_sprite_track #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] fg_word,
  output logic              active
);
  localparam int FLAG_BIT = WORD_W - 1;
  localparam int MARK_BIT = WORD_W - 2;

  logic is_end;
  logic end_q;
  logic active_q;

  assign is_end = fg_word[FLAG_BIT] & fg_word[MARK_BIT];

  // End marker is retimed through one register before it acts.
  always_ff @(posedge clk) begin
    if (rst) begin
      end_q <= 1'b0;
    end else begin
      end_q <= is_end;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
    end else if (end_q) begin
      active_q <= 1'b0;
    end
  end

  assign active = active_q;

  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> active);
  assert_end_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (is_end && !start) ##1 !start |=> !active);
  assert_end_delay_R6: assert property (@(posedge clk) disable iff (rst)
    (active && is_end && !start) |=> active);
  assert_start_beats_end_R7: assert property (@(posedge clk) disable iff (rst)
    (end_q && start) |=> active);
endmodule

// File: rtl/spc_pixel_select.sv
module spc_pixel_select #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [WORD_W-1:0] fg_word,
  input  logic [WORD_W-1:0] bg_word,
  output logic [WORD_W-2:0] rgb
);
  localparam int RGB_W    = WORD_W - 1;
  localparam int FLAG_BIT = WORD_W - 1;

  logic             use_fg;
  logic [RGB_W-1:0] pick;
  logic [RGB_W-1:0] rgb_q;

  always_comb begin
    use_fg = active & ~fg_word[FLAG_BIT];
    pick   = use_fg ? fg_word[RGB_W-1:0] : bg_word[RGB_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_q <= '0;
    end else begin
      rgb_q <= pick;
    end
  end

  assign rgb = rgb_q;

  assert_sprite_pick_R8: assert property (@(posedge clk) disable iff (rst)
    (active && !fg_word[FLAG_BIT]) |=> rgb == $past(fg_word[RGB_W-1:0]));
  assert_bg_pick_R8: assert property (@(posedge clk) disable iff (rst)
    (!active || fg_word[FLAG_BIT]) |=> rgb == $past(bg_word[RGB_W-1:0]));
endmodule

// File: rtl/sprite_compositor.sv
module sprite_compositor #(
  parameter int POS_W  = 12,
  parameter int PAGE_W = 6,
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv_en,
  input  logic [PAGE_W-1:0]       page_val,
  input  logic                    bg_page_wr,
  input  logic                    fg_page_wr,
  input  logic [POS_W-1:0]        pos_val,
  input  logic                    bg_pos_ld,
  input  logic                    fg_pos_ld,
  input  logic [WORD_W-1:0]       bg_rdata,
  input  logic [WORD_W-1:0]       fg_rdata,
  output logic [POS_W+PAGE_W-1:0] bg_addr,
  output logic [POS_W+PAGE_W-1:0] fg_addr,
  output logic [WORD_W-2:0]       rgb_out
);
  import spc_pkg::*;

  localparam int ADDR_W = POS_W + PAGE_W;

  logic [NUM_PLANES-1:0] page_wr_v;
  logic [NUM_PLANES-1:0] pos_ld_v;
  logic [ADDR_W-1:0]     addr_v [NUM_PLANES];
  logic                  sprite_on;

  assign page_wr_v[PLANE_BG] = bg_page_wr;
  assign page_wr_v[PLANE_FG] = fg_page_wr;
  assign pos_ld_v[PLANE_BG]  = bg_pos_ld;
  assign pos_ld_v[PLANE_FG]  = fg_pos_ld;

  for (genvar g = 0; g < NUM_PLANES; g++) begin : g_plane
    spc_plane_addr #(
      .POS_W (POS_W),
      .PAGE_W(PAGE_W)
    ) u_addr (
      .clk     (clk),
      .rst     (rst),
      .page_wr (page_wr_v[g]),
      .page_val(page_val),
      .pos_ld  (pos_ld_v[g]),
      .pos_val (pos_val),
      .adv_en  (adv_en),
      .addr    (addr_v[g])
    );
  end

  assign bg_addr = addr_v[PLANE_BG];
  assign fg_addr = addr_v[PLANE_FG];

  spc_sprite_track #(.WORD_W(WORD_W)) u_track (
    .clk    (clk),
    .rst    (rst),
    .start  (fg_pos_ld),
    .fg_word(fg_rdata),
    .active (sprite_on)
  );

  spc_pixel_select #(.WORD_W(WORD_W)) u_select (
    .clk    (clk),
    .rst    (rst),
    .active (sprite_on),
    .fg_word(fg_rdata),
    .bg_word(bg_rdata),
    .rgb    (rgb_out)
  );

  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> (bg_addr == '0) && (fg_addr == '0) && (rgb_out == '0));
endmodule

// File: tb/test_sprite_compositor.sv
module test_sprite_compositor;
  localparam int CLK_PERIOD = 40;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        adv_en;
  logic [5:0]  page_val;
  logic        bg_page_wr, fg_page_wr;
  logic [11:0] pos_val;
  logic        bg_pos_ld, fg_pos_ld;
  logic [15:0] bg_rdata, fg_rdata;
  logic [17:0] bg_addr, fg_addr;
  logic [14:0] rgb_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // {start, fg word, bg word, expected rgb}
  localparam logic [47:0] VEC [NVEC] = '{
    {1'b0, 16'h0111, 16'h0AAA, 15'h0AAA}, // idle -> background
    {1'b1, 16'h0222, 16'h0BBB, 15'h0BBB}, // start; not yet active
    {1'b0, 16'h0333, 16'h0CCC, 15'h0333}, // R5 sprite shown
    {1'b0, 16'h8444, 16'h0DDD, 15'h0DDD}, // R8 transparent -> bg
    {1'b0, 16'h1555, 16'h8EEE, 15'h1555}, // sprite opaque
    {1'b0, 16'hC123, 16'h0F0F, 15'h0F0F}, // R6 end marker, bg shown
    {1'b0, 16'h0246, 16'h1111, 15'h0246}, // R6 still active one pixel
    {1'b0, 16'h0357, 16'hA222, 15'h2222}, // R9 inactive, bg bit15 dropped
    {1'b0, 16'hC000, 16'h3333, 15'h3333}, // R6 marker while inactive
    {1'b1, 16'h0468, 16'h4444, 15'h4444}, // R7 start with pending end
    {1'b0, 16'h0579, 16'h5555, 15'h0579}, // R7 start survived
    {1'b0, 16'h4ABC, 16'h6666, 15'h4ABC}, // R8 bit14 alone is colour
    {1'b0, 16'h0DEF, 16'h7777, 15'h0DEF}, // still active
    {1'b1, 16'hC001, 16'h1234, 15'h1234}, // R5 restart while active + marker
    {1'b0, 16'h0100, 16'h2345, 15'h0100}, // start kept it; end pending
    {1'b0, 16'h0200, 16'h3456, 15'h3456}  // R6 cleared
  };

  sprite_compositor i_sprite_compositor (
    .clk(clk), .rst(rst), .adv_en(adv_en), .page_val(page_val),
    .bg_page_wr(bg_page_wr), .fg_page_wr(fg_page_wr), .pos_val(pos_val),
    .bg_pos_ld(bg_pos_ld), .fg_pos_ld(fg_pos_ld), .bg_rdata(bg_rdata),
    .fg_rdata(fg_rdata), .bg_addr(bg_addr), .fg_addr(fg_addr), .rgb_out(rgb_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; adv_en = 1; page_val = 6'h3F; bg_page_wr = 1; fg_page_wr = 1;
    pos_val = 12'h555; bg_pos_ld = 1; fg_pos_ld = 1;
    bg_rdata = 16'h7FFF; fg_rdata = 16'h0123;
    tick(); tick(); tick();
    check("R10 bg_addr", 32'(bg_addr), 32'h0);
    check("R10 fg_addr", 32'(fg_addr), 32'h0);
    check("R10 rgb_out", 32'(rgb_out), 32'h0);

    // Page preload, then position load
    rst = 0; bg_page_wr = 1; fg_page_wr = 0; bg_pos_ld = 0; fg_pos_ld = 0;
    adv_en = 0; page_val = 6'h2A; fg_rdata = 16'h0000; bg_rdata = 16'h0000;
    tick();
    bg_page_wr = 0; bg_pos_ld = 1; pos_val = 12'h100;
    tick();
    check("R1/R2 bg_addr after page+load", 32'(bg_addr), 32'h2A100);
    check("R1 fg page untouched", 32'(fg_addr), 32'h0);
    bg_pos_ld = 0; adv_en = 1;
    tick(); tick(); tick();
    check("R3 advance x3", 32'(bg_addr), 32'h2A103);
    adv_en = 0;
    tick(); tick();
    check("R3 hold", 32'(bg_addr), 32'h2A103);

    // Load wins over advance, then wrap
    bg_pos_ld = 1; adv_en = 1; pos_val = 12'hFFE;
    tick();
    check("R2 load beats advance", 32'(bg_addr), 32'h2AFFE);
    bg_pos_ld = 0;
    tick(); tick(); tick();
    check("R4 wrap inside page", 32'(bg_addr), 32'h2A001);

    // Sprite page alone
    adv_en = 0; fg_page_wr = 1; page_val = 6'h15;
    tick();
    fg_page_wr = 0;
    check("R1 fg page loaded", 32'(fg_addr[17:12]), 32'h15);
    check("R1 bg page kept", 32'(bg_addr), 32'h2A001);
    tick();
    check("R9 rgb follows bg", 32'(rgb_out), 32'h0);

    // Pixel stream vectors
    adv_en = 1;
    for (int i = 0; i < NVEC; i++) begin
      fg_pos_ld = VEC[i][47];
      fg_rdata  = VEC[i][46:31];
      bg_rdata  = VEC[i][30:15];
      tick();
      check($sformatf("R5-R9 stream vec %0d", i), 32'(rgb_out), 32'(VEC[i][14:0]));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule